// File: doc/BRIEF.md
# Self-Timed Channel Monitor with Threshold Alerts

This block lets a converter watch several analog inputs without any host traffic. An internal timer issues a one-cycle convert-start pulse at a chosen period. A channel-select output walks through a programmed list of channel numbers. The converter returns each result on a strobe that carries the channel tag and the data. The block tests every result against that channel's upper and lower limits, and it applies a separate hysteresis band to each channel. When a limit is newly crossed, a sticky flag is set. An interrupt line forms from the flags that the host has chosen to watch, so the host can stay asleep until the interrupt fires.

The host configures the block through a write-only register port. The address groups are: control words at 0x00 to 0x03, sequence entries at 0x10 + entry, upper limits at 0x20 + channel, lower limits at 0x30 + channel, and hysteresis at 0x40 + channel. The host clears flags by writing ones to them.

Top module: `acs_monitor`

## Requirements
- R1: The control word at 0x00 holds the enable in bit 0, the period code in bits 3:1 and the last sequence index in bits 7:4. Codes 0 to 7 select 10, 20, 40, 80, 160, 320, 640 and 800 µs, which is CLK_MHZ × µs clock cycles (P). After the write that sets the enable, `conv_start` is high for one cycle on the P-th cycle. After that it pulses every P cycles.
- R2: `chan_sel` shows the channel stored in the current sequence entry. It holds that value from the start pulse until the result strobe. It then moves to the next entry and wraps to entry 0 after the last index.
- R3: A write to 0x10 + e stores the channel number in bits CH_W-1:0 as sequence entry e (0 to 15). All entries reset to channel 0.
- R4: A result strobe updates only the channel named by `res_chan`. A result strictly above that channel's upper limit (0x20 + c) makes its upper level active. If the level was inactive, this sets `alert_hi[c]`.
- R5: An active upper level goes inactive only when a result is strictly below the upper limit minus the hysteresis (0x40 + c). Results inside the band leave the level as it is.
- R6: The lower level is the mirror image. A result strictly below the lower limit (0x30 + c) activates it and sets `alert_lo[c]` if the level was inactive. Only a result strictly above the lower limit plus the hysteresis releases it.
- R7: Flags are sticky. Writing ones to 0x01 (upper flags) or 0x02 (lower flags) clears them. A flag cleared while its level is still active stays clear until the level is released and then crossed again.
- R8: `irq` is the OR of the flags whose channel bit is set in the mask at 0x03. It applies to both the upper and the lower flag of that channel. Flags whose mask bit is 0 have no effect on `irq`.
- R9: Clearing the enable stops new start pulses. A conversion already in flight still has its result tested. Once idle, the block returns to entry 0, and re-enabling waits a full period P before the first pulse.
- R10: After reset, `conv_start`, all flags, `irq` and the mask are 0, and `chan_sel` is 0. Upper limits reset to all ones, and lower limits and hysteresis reset to 0, so no result can trip an alert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 7 | Configuration register address |
| cfg_wdata | input | DATA_W | Configuration write data |
| res_valid | input | 1 | Conversion result strobe |
| res_chan | input | CH_W | Channel tag of the result |
| res_data | input | DATA_W | Conversion result |
| conv_start | output | 1 | One-cycle convert-start pulse |
| chan_sel | output | CH_W | Channel to convert |
| alert_hi | output | NUM_CH | Sticky upper-limit flags |
| alert_lo | output | NUM_CH | Sticky lower-limit flags |
| irq | output | 1 | Interrupt to the host |

## Verification
The threshold logic is driven with results at exactly the limit, one count beyond it, inside the hysteresis band, on the band edge and just past the band edge. These cases separate a strict compare from an inclusive one and show whether the release point is off by one. Repeated crossings while a level is active, sent after a flag clear, show that flags fire on level transitions and not on every result above the limit. The timer is tried with the shortest, a middle and the longest period code. A four-entry list that repeats a channel shows both the ordering and the wrap. A disable placed inside an in-flight conversion tells the "finish then stop" behaviour apart from an immediate abort.

// File: rtl/acs_pkg.sv
package acs_pkg;
  localparam int CODE_W    = 3;
  localparam int SEQ_W     = 4;
  localparam int SEQ_DEPTH = 1 << SEQ_W;
  localparam int ADDR_W    = 7;

  typedef enum logic [2:0] {
    GRP_CTRL = 3'd0,
    GRP_SEQ  = 3'd1,
    GRP_HI   = 3'd2,
    GRP_LO   = 3'd3,
    GRP_HYS  = 3'd4
  } reg_grp_e;

  localparam logic [3:0] OFS_CTRL  = 4'd0;
  localparam logic [3:0] OFS_CLRHI = 4'd1;
  localparam logic [3:0] OFS_CLRLO = 4'd2;
  localparam logic [3:0] OFS_MASK  = 4'd3;

  function automatic int unsigned period_us(input logic [CODE_W-1:0] code);
    case (code)
      3'd0:    return 10;
      3'd1:    return 20;
      3'd2:    return 40;
      3'd3:    return 80;
      3'd4:    return 160;
      3'd5:    return 320;
      3'd6:    return 640;
      default: return 800;
    endcase
  endfunction
endpackage

// File: rtl/acs_timer.sv
module acs_timer
  import acs_pkg::*;
#(
  parameter int CLK_MHZ = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [CODE_W-1:0] code,
  output logic              conv_start
);
  localparam int MAX_CYC = CLK_MHZ * 800;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d, limit;
  logic             tick;

  always_comb begin
    limit = CNT_W'(CLK_MHZ * period_us(code) - 1);
    tick  = run && (cnt_q >= limit);
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign conv_start = tick;

  // R1: start is a single-cycle pulse
  assert_single_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
endmodule

// File: rtl/acs_seq.sv
module acs_seq
  import acs_pkg::*;
#(
  parameter int CH_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             conv_start,
  input  logic             res_valid,
  input  logic             seq_we,
  input  logic [SEQ_W-1:0] seq_idx,
  input  logic [CH_W-1:0]  seq_ch,
  input  logic [SEQ_W-1:0] last_idx,
  output logic [CH_W-1:0]  chan_sel
);
  logic [CH_W-1:0]  ent [SEQ_DEPTH];
  logic [SEQ_W-1:0] ptr_q, ptr_d;
  logic             busy_q, busy_d;

  for (genvar e = 0; e < SEQ_DEPTH; e++) begin : g_entry
    logic            ent_we;
    logic [CH_W-1:0] ent_q;
    assign ent_we = seq_we && (seq_idx == SEQ_W'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q <= '0;
      else if (ent_we) ent_q <= seq_ch;
    end
    assign ent[e] = ent_q;
  end

  always_comb begin
    busy_d = busy_q;
    ptr_d  = ptr_q;
    if (conv_start)     busy_d = 1'b1;
    else if (res_valid) busy_d = 1'b0;
    if (res_valid && busy_q)
      ptr_d = (ptr_q >= last_idx) ? '0 : ptr_q + SEQ_W'(1);
    if (!en && !busy_q) ptr_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ptr_q  <= '0;
    end else begin
      busy_q <= busy_d;
      ptr_q  <= ptr_d;
    end
  end

  assign chan_sel = ent[ptr_q];

  // R2: selection holds while a conversion is in flight
  assert_sel_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !res_valid && !seq_we) |=> $stable(chan_sel));
endmodule

// File: rtl/acs_chan_mon.sv
module acs_chan_mon #(
  parameter int DATA_W = 16,
  parameter int CH_W   = 3,
  parameter int IDX    = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  input  logic [CH_W-1:0]   res_chan,
  input  logic [DATA_W-1:0] res_data,
  input  logic              hi_we,
  input  logic              lo_we,
  input  logic              hys_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              clr_hi,
  input  logic              clr_lo,
  output logic              flag_hi,
  output logic              flag_lo
);
  logic [DATA_W-1:0] hi_q, lo_q, hys_q;
  logic              hi_act_q, hi_act_d, lo_act_q, lo_act_d;
  logic              fhi_q, fhi_d, flo_q, flo_d;
  logic              hit, over_hi, under_rel, under_lo, over_rel;

  always_comb begin
    hit       = res_valid && (res_chan == CH_W'(IDX));
    over_hi   = res_data > hi_q;
    under_rel = ({1'b0, res_data} + {1'b0, hys_q}) < {1'b0, hi_q};
    under_lo  = res_data < lo_q;
    over_rel  = {1'b0, res_data} > ({1'b0, lo_q} + {1'b0, hys_q});

    hi_act_d = hi_act_q;
    lo_act_d = lo_act_q;
    if (hit) begin
      if (over_hi)        hi_act_d = 1'b1;
      else if (under_rel) hi_act_d = 1'b0;
      if (under_lo)       lo_act_d = 1'b1;
      else if (over_rel)  lo_act_d = 1'b0;
    end

    if (hit && over_hi && !hi_act_q)  fhi_d = 1'b1;
    else if (clr_hi)                  fhi_d = 1'b0;
    else                              fhi_d = fhi_q;
    if (hit && under_lo && !lo_act_q) flo_d = 1'b1;
    else if (clr_lo)                  flo_d = 1'b0;
    else                              flo_d = flo_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '1;
      lo_q  <= '0;
      hys_q <= '0;
    end else begin
      if (hi_we)  hi_q  <= wdata;
      if (lo_we)  lo_q  <= wdata;
      if (hys_we) hys_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_act_q <= 1'b0;
      lo_act_q <= 1'b0;
      fhi_q    <= 1'b0;
      flo_q    <= 1'b0;
    end else begin
      hi_act_q <= hi_act_d;
      lo_act_q <= lo_act_d;
      fhi_q    <= fhi_d;
      flo_q    <= flo_d;
    end
  end

  assign flag_hi = fhi_q;
  assign flag_lo = flo_q;

  assert_hi_trip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && (res_data > hi_q)) |=> (hi_act_q && flag_hi || hi_act_q && $past(hi_act_q)));
  assert_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> ($stable(hi_act_q) && $stable(lo_act_q)));
  // R5: results inside the upper band leave the level unchanged
  assert_band_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !(res_data > hi_q) && (({1'b0, res_data} + {1'b0, hys_q}) >= {1'b0, hi_q}))
      |=> $stable(hi_act_q));
  assert_lo_trip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && (res_data < lo_q)) |=> lo_act_q);
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_hi && !clr_hi) |=> flag_hi);
endmodule

// File: rtl/acs_monitor.sv
module acs_monitor
  import acs_pkg::*;
#(
  parameter int CLK_MHZ = 50,
  parameter int NUM_CH  = 8,
  parameter int DATA_W  = 16,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [6:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              res_valid,
  input  logic [CH_W-1:0]   res_chan,
  input  logic [DATA_W-1:0] res_data,
  output logic              conv_start,
  output logic [CH_W-1:0]   chan_sel,
  output logic [NUM_CH-1:0] alert_hi,
  output logic [NUM_CH-1:0] alert_lo,
  output logic              irq
);
  logic [1:0]        rst_sync;
  logic              rst_n_s;
  reg_grp_e          grp;
  logic [3:0]        ofs;
  logic              wr_ctrl, wr_mask, wr_seq;
  logic [NUM_CH-1:0] clr_hi, clr_lo;
  logic              en_q, en_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic [SEQ_W-1:0]  last_q, last_d;
  logic [NUM_CH-1:0] mask_q, mask_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  always_comb begin
    grp     = reg_grp_e'(cfg_addr[6:4]);
    ofs     = cfg_addr[3:0];
    wr_ctrl = cfg_we && (grp == GRP_CTRL) && (ofs == OFS_CTRL);
    wr_mask = cfg_we && (grp == GRP_CTRL) && (ofs == OFS_MASK);
    wr_seq  = cfg_we && (grp == GRP_SEQ);
    clr_hi  = (cfg_we && (grp == GRP_CTRL) && (ofs == OFS_CLRHI)) ? cfg_wdata[NUM_CH-1:0] : '0;
    clr_lo  = (cfg_we && (grp == GRP_CTRL) && (ofs == OFS_CLRLO)) ? cfg_wdata[NUM_CH-1:0] : '0;
    en_d    = en_q;
    code_d  = code_q;
    last_d  = last_q;
    mask_d  = mask_q;
    if (wr_ctrl) {last_d, code_d, en_d} = cfg_wdata[7:0];
    if (wr_mask) mask_d = cfg_wdata[NUM_CH-1:0];
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      en_q   <= 1'b0;
      code_q <= '0;
      last_q <= '0;
      mask_q <= '0;
    end else begin
      en_q   <= en_d;
      code_q <= code_d;
      last_q <= last_d;
      mask_q <= mask_d;
    end
  end

  acs_timer #(.CLK_MHZ(CLK_MHZ)) u_timer (
    .clk(clk), .rst_n(rst_n_s), .run(en_q), .code(code_q), .conv_start(conv_start)
  );

  acs_seq #(.CH_W(CH_W)) u_seq (
    .clk(clk), .rst_n(rst_n_s), .en(en_q), .conv_start(conv_start),
    .res_valid(res_valid), .seq_we(wr_seq), .seq_idx(ofs),
    .seq_ch(cfg_wdata[CH_W-1:0]), .last_idx(last_q), .chan_sel(chan_sel)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hi_we, lo_we, hys_we;
    assign hi_we  = cfg_we && (grp == GRP_HI)  && (ofs == 4'(c));
    assign lo_we  = cfg_we && (grp == GRP_LO)  && (ofs == 4'(c));
    assign hys_we = cfg_we && (grp == GRP_HYS) && (ofs == 4'(c));
    acs_chan_mon #(.DATA_W(DATA_W), .CH_W(CH_W), .IDX(c)) u_mon (
      .clk(clk), .rst_n(rst_n_s), .res_valid(res_valid), .res_chan(res_chan),
      .res_data(res_data), .hi_we(hi_we), .lo_we(lo_we), .hys_we(hys_we),
      .wdata(cfg_wdata), .clr_hi(clr_hi[c]), .clr_lo(clr_lo[c]),
      .flag_hi(alert_hi[c]), .flag_lo(alert_lo[c])
    );
  end

  assign irq = |((alert_hi | alert_lo) & mask_q);

  assert_irq_src_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    irq |-> (|(alert_hi | alert_lo)));
  assert_no_start_idle_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    !en_q |=> !conv_start);
endmodule

// File: tb/test_acs_monitor.sv
`timescale 1ns/1ps
module test_acs_monitor;
  localparam int LAT = 6;
  localparam int MHZ = 50;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [6:0]  cfg_addr;
  logic [15:0] cfg_wdata;
  logic        res_valid;
  logic [2:0]  res_chan;
  logic [15:0] res_data;
  logic        conv_start;
  logic [2:0]  chan_sel;
  logic [7:0]  alert_hi, alert_lo;
  logic        irq;

  logic        man_valid, mdl_valid;
  logic [2:0]  man_ch, mdl_chv;
  logic [15:0] man_data, mdl_data;
  int          mdl_cnt, mdl_ch;
  int          adc_val [8];
  int          nchk = 0, nfail = 0;

  always #10 clk = ~clk;

  assign res_valid = man_valid | mdl_valid;
  assign res_chan  = mdl_valid ? mdl_chv : man_ch;
  assign res_data  = mdl_valid ? mdl_data : man_data;

  acs_monitor i_acs_monitor (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .res_valid(res_valid), .res_chan(res_chan),
    .res_data(res_data), .conv_start(conv_start), .chan_sel(chan_sel),
    .alert_hi(alert_hi), .alert_lo(alert_lo), .irq(irq)
  );

  // converter model: fixed latency result strobe
  initial begin
    mdl_valid = 1'b0; mdl_cnt = 0; mdl_ch = 0; mdl_chv = '0; mdl_data = '0;
  end
  always @(negedge clk) begin
    if (mdl_valid) mdl_valid = 1'b0;
    if (mdl_cnt > 0) begin
      mdl_cnt = mdl_cnt - 1;
      if (mdl_cnt == 0) begin
        mdl_valid = 1'b1;
        mdl_chv   = 3'(mdl_ch);
        mdl_data  = 16'(adc_val[mdl_ch]);
      end
    end
    if (conv_start) begin
      mdl_cnt = LAT;
      mdl_ch  = int'(chan_sel);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input int addr, input int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 7'(addr); cfg_wdata = 16'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic int ctrl(input int en, input int code, input int last);
    return (last << 4) | (code << 1) | en;
  endfunction

  task automatic apply(input int ch, input int data);
    @(negedge clk);
    man_valid = 1'b1; man_ch = 3'(ch); man_data = 16'(data);
    @(negedge clk);
    man_valid = 1'b0;
  endtask

  task automatic wait_pulse(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!conv_start && n < 50000);
  endtask

  task automatic first_delay(input string tag, input int p, output int got);
    got = -1;
    for (int i = 1; i <= p + 2; i++) begin
      if (i > 1) @(negedge clk);
      if (conv_start) begin
        got = i;
        break;
      end
    end
    chk(tag, got, p);
  endtask

  task automatic stop_run(input int last);
    cfg_write(8'h00, ctrl(0, 0, last));
    repeat (LAT + 4) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R10 conv_start", int'(conv_start), 0);
    chk("R10 irq", int'(irq), 0);
    chk("R10 alert_hi", int'(alert_hi), 0);
    chk("R10 alert_lo", int'(alert_lo), 0);
    chk("R10 chan_sel", int'(chan_sel), 0);
    apply(0, 16'hFFFF);
    chk("R10 default upper limit", int'(alert_hi[0]), 0);
    apply(0, 0);
    chk("R10 default lower limit", int'(alert_lo[0]), 0);
  endtask

  task automatic t_upper;
    cfg_write(8'h22, 1000);
    cfg_write(8'h42, 100);
    apply(2, 1000);
    chk("R4 equal to limit", int'(alert_hi[2]), 0);
    apply(2, 1001);
    chk("R4 above limit", int'(alert_hi[2]), 1);
    chk("R8 masked irq", int'(irq), 0);
    apply(3, 5000);
    chk("R4 other channel untouched", int'(alert_hi[3]), 0);
    cfg_write(8'h01, 1 << 2);
    chk("R7 w1c upper", int'(alert_hi[2]), 0);
    apply(2, 1200);
    chk("R7 no refire while active", int'(alert_hi[2]), 0);
    apply(2, 950);
    apply(2, 900);
    chk("R5 band edge holds", int'(alert_hi[2]), 0);
    apply(2, 1001);
    chk("R5 still active in band", int'(alert_hi[2]), 0);
    apply(2, 899);
    apply(2, 1001);
    chk("R5 refire after release", int'(alert_hi[2]), 1);
    chk("R4 lower flag untouched", int'(alert_lo[2]), 0);
  endtask

  task automatic t_lower;
    cfg_write(8'h34, 200);
    cfg_write(8'h44, 50);
    apply(4, 200);
    chk("R6 equal to limit", int'(alert_lo[4]), 0);
    apply(4, 199);
    chk("R6 below limit", int'(alert_lo[4]), 1);
    cfg_write(8'h02, 1 << 4);
    chk("R7 w1c lower", int'(alert_lo[4]), 0);
    apply(4, 250);
    apply(4, 199);
    chk("R6 band edge holds", int'(alert_lo[4]), 0);
    apply(4, 251);
    apply(4, 199);
    chk("R6 refire after release", int'(alert_lo[4]), 1);
  endtask

  task automatic t_irq;
    chk("R8 mask zero", int'(irq), 0);
    cfg_write(8'h03, 1 << 4);
    chk("R8 lower flag unmasked", int'(irq), 1);
    cfg_write(8'h01, 1 << 2);
    chk("R7 upper clear keeps lower", int'(alert_lo[4]), 1);
    chk("R8 irq from lower", int'(irq), 1);
    cfg_write(8'h02, 1 << 4);
    chk("R8 irq drops on clear", int'(irq), 0);
    cfg_write(8'h03, 1 << 2);
    chk("R8 mask on clear flag", int'(irq), 0);
    cfg_write(8'h03, 0);
  endtask

  task automatic t_period;
    int got, n;
    cfg_write(8'h00, ctrl(1, 7, 0));
    first_delay("R1 first pulse code 7", MHZ * 800, got);
    @(negedge clk);
    chk("R1 single cycle pulse", int'(conv_start), 0);
    stop_run(0);
    cfg_write(8'h00, ctrl(1, 0, 0));
    wait_pulse(n);
    wait_pulse(n);
    chk("R1 interval code 0", n, MHZ * 10);
    stop_run(0);
    cfg_write(8'h00, ctrl(1, 3, 0));
    wait_pulse(n);
    wait_pulse(n);
    chk("R1 interval code 3", n, MHZ * 80);
    stop_run(0);
  endtask

  task automatic t_sequence;
    int exp_ch [4] = '{5, 1, 6, 1};
    int n;
    for (int e = 0; e < 4; e++) cfg_write(8'h10 + e, exp_ch[e]);
    cfg_write(8'h00, ctrl(1, 0, 3));
    for (int k = 0; k < 6; k++) begin
      wait_pulse(n);
      chk("R2 R3 sequence order", int'(chan_sel), exp_ch[k % 4]);
      if (k == 0) begin
        repeat (LAT) @(negedge clk);
        chk("R2 hold until result", int'(chan_sel), exp_ch[0]);
        @(negedge clk);
        chk("R2 advance after result", int'(chan_sel), exp_ch[1]);
      end
    end
    stop_run(3);
  endtask

  task automatic t_disable;
    int n, got, seen;
    cfg_write(8'h01, 8'hFF);
    cfg_write(8'h02, 8'hFF);
    cfg_write(8'h25, 100);
    adc_val[5] = 500;
    cfg_write(8'h00, ctrl(1, 0, 3));
    wait_pulse(n);
    chk("R9 first entry", int'(chan_sel), 5);
    cfg_write(8'h00, ctrl(0, 0, 3));
    repeat (LAT + 2) @(negedge clk);
    chk("R9 in-flight result tested", int'(alert_hi[5]), 1);
    seen = 0;
    for (int i = 0; i < 1200; i++) begin
      @(negedge clk);
      if (conv_start) seen++;
    end
    chk("R9 no pulse after disable", seen, 0);
    chk("R9 idle returns to entry 0", int'(chan_sel), 5);
    cfg_write(8'h00, ctrl(1, 0, 3));
    first_delay("R9 full period on restart", MHZ * 10, got);
    chk("R9 restart at entry 0", int'(chan_sel), 5);
    stop_run(3);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL R1 watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    man_valid = 1'b0; man_ch = '0; man_data = '0;
    for (int c = 0; c < 8; c++) adc_val[c] = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_upper;
    t_lower;
    t_irq;
    t_period;
    t_sequence;
    t_disable;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule